// File: doc/BRIEF.md
# Speculative Critical-Section Tracker

This block lets a core run a lock-guarded region without taking the lock. When the pipeline signals an acquire hint while the block is idle, the block asks for a register snapshot and enters speculative mode. The lock variable itself is never stored to. While speculative, every local load and store reports its cache-line index. The block keeps a per-line flag for lines that were read and a per-line flag for lines that were written.

Coherence requests from other agents are checked against those flags. If a request collides with the footprint, the block aborts. It asks for the snapshot to be restored and hands the cache a mask of every line written during speculation, so that those lines can be dropped. A matching release hint with no collision produces a single commit pulse. That pulse makes all buffered stores visible at once. Running out of tracking room, or a second acquire while already speculative, also aborts the region. In those two cases the block additionally raises a fallback pulse, which tells the core to retry with a real lock.

Top module: `spec_lock_tracker`

## Requirements
- R1: While and right after reset, every output is 0 and the block is not speculative.
- R2: An acquire hint while idle gives, one cycle later, a one-cycle `ckpt_save_o` pulse, and `spec_active_o` goes high at the same time; no other output changes.
- R3: A release hint while speculative, with no abort cause in that cycle, gives a one-cycle `commit_o` pulse one cycle later and `spec_active_o` drops; `commit_o` and `abort_o` are never high together.
- R4: A remote read request (`snp_kind_i` = 2'b00) on a line that was only read speculatively causes no abort.
- R5: A remote read request on a line written speculatively causes an abort one cycle later.
- R6: A write-class request (`snp_kind_i` 2'b01 write, 2'b10 invalidate, 2'b11 treated as write) on a line with either flag set causes an abort; a request on an untouched line causes nothing.
- R7: On abort, `abort_o` and `ckpt_restore_o` pulse for one cycle together, and `inval_mask_o` bit i is 1 exactly when line i was written during speculation, including a store reported in the aborting cycle. At all other times `inval_mask_o` is 0.
- R8: An access to a new line when CAP distinct lines are already tracked aborts with `fallback_o` = 1; a conflict-only abort has `fallback_o` = 0.
- R9: An acquire hint while speculative aborts with `fallback_o` = 1.
- R10: A conflict or other abort cause in the same cycle as the release hint aborts and does not commit.
- R11: Both flags of every line are cleared on commit and on abort, so a later region does not see earlier lines.
- R12: While idle, accesses, snoops and release hints have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_hint_i | input | 1 | Lock-acquire hint from the pipeline |
| rel_hint_i | input | 1 | Lock-release hint from the pipeline |
| acc_valid_i | input | 1 | A local access is reported |
| acc_write_i | input | 1 | Reported access is a store |
| acc_line_i | input | LINE_W | Line index of the local access |
| snp_valid_i | input | 1 | Incoming coherence request valid |
| snp_kind_i | input | 2 | Request kind: 00 read, 01 write, 10 invalidate, 11 write |
| snp_line_i | input | LINE_W | Line index of the coherence request |
| spec_active_o | output | 1 | Speculative mode is active |
| ckpt_save_o | output | 1 | Take the register snapshot (pulse) |
| ckpt_restore_o | output | 1 | Restore the register snapshot (pulse) |
| commit_o | output | 1 | Publish all speculative stores (pulse) |
| abort_o | output | 1 | Speculation abandoned (pulse) |
| fallback_o | output | 1 | Retry with a real lock (pulse, with abort) |
| inval_mask_o | output | 2**LINE_W | Lines to invalidate, valid with abort |

## Verification
Every result of this block is due exactly one cycle after the clock edge that samples its cause. This covers the save pulse, the commit or abort pulse, the restore and fallback pulses, the invalidation mask and the change of `spec_active_o`. The bench applies each stimulus at a falling edge. It predicts the outputs from its own model of the flag state before the next rising edge, and compares them at the following falling edge. No pulse can therefore be sampled early or late, and a pulse held for a second cycle shows up as a mismatch in the next comparison. Directed sequences place a snoop, a store, an overflow or a nested acquire into the same cycle as a release. They also test lines left over from an earlier region. Random traffic on a narrow band of lines then makes hits frequent.

// File: rtl/slt_pkg.sv
package slt_pkg;
  typedef enum logic [1:0] {
    SNP_RD  = 2'b00,
    SNP_WR  = 2'b01,
    SNP_INV = 2'b10,
    SNP_RSV = 2'b11
  } snp_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SPEC = 1'b1
  } spec_state_e;
endpackage

// File: rtl/slt_footprint.sv
module slt_footprint #(
  parameter int LINE_W = 6,
  parameter int CAP    = 8,
  localparam int NUM_LINES = 1 << LINE_W,
  localparam int CNT_W     = $clog2(CAP + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_i,
  input  logic                 rec_en_i,
  input  logic                 rec_wr_i,
  input  logic [LINE_W-1:0]    rec_line_i,
  input  logic [LINE_W-1:0]    look_line_i,
  output logic                 look_rd_o,
  output logic                 look_wr_o,
  output logic                 ovf_o,
  output logic [NUM_LINES-1:0] wr_bits_o
);
  logic [NUM_LINES-1:0] rd_q, wr_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 new_line, accept;

  assign new_line  = !(rd_q[rec_line_i] || wr_q[rec_line_i]);
  assign ovf_o     = rec_en_i && new_line && (cnt_q == CNT_W'(CAP));
  assign accept    = rec_en_i && !ovf_o;
  assign look_rd_o = rd_q[look_line_i];
  assign look_wr_o = wr_q[look_line_i];
  assign wr_bits_o = wr_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit;
    assign hit = accept && (rec_line_i == LINE_W'(g));
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        rd_q[g] <= 1'b0;
        wr_q[g] <= 1'b0;
      end else if (hit) begin
        if (rec_wr_i) wr_q[g] <= 1'b1;
        else          rd_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)            cnt_q <= '0;
    else if (accept && new_line) cnt_q <= cnt_q + 1'b1;
  end

  // R8
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(CAP));

  // R11
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/slt_snoop_chk.sv
module slt_snoop_chk
  import slt_pkg::*;
(
  input  logic       spec_i,
  input  logic       snp_valid_i,
  input  logic [1:0] kind_i,
  input  logic       rd_hit_i,
  input  logic       wr_hit_i,
  output logic       conflict_o
);
  snp_kind_e kind;
  logic      excl;

  assign kind       = snp_kind_e'(kind_i);
  assign excl       = (kind != SNP_RD);
  assign conflict_o = spec_i && snp_valid_i &&
                      (excl ? (rd_hit_i || wr_hit_i) : wr_hit_i);
endmodule

// File: rtl/slt_ctrl.sv
module slt_ctrl
  import slt_pkg::*;
#(
  parameter int LINE_W = 6,
  localparam int NUM_LINES = 1 << LINE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acq_i,
  input  logic                 rel_i,
  input  logic                 acc_valid_i,
  input  logic                 acc_wr_i,
  input  logic [LINE_W-1:0]    acc_line_i,
  input  logic                 conflict_i,
  input  logic                 ovf_i,
  input  logic [NUM_LINES-1:0] wr_bits_i,
  output logic                 spec_o,
  output logic                 rec_en_o,
  output logic                 clr_o,
  output logic                 save_o,
  output logic                 commit_o,
  output logic                 abort_o,
  output logic                 restore_o,
  output logic                 fallback_o,
  output logic [NUM_LINES-1:0] mask_o
);
  spec_state_e          st_q;
  logic                 nest, abort_now, commit_now, enter;
  logic [NUM_LINES-1:0] new_wr;

  assign spec_o     = (st_q == ST_SPEC);
  assign nest       = spec_o && acq_i;
  assign abort_now  = spec_o && (conflict_i || ovf_i || nest);
  assign commit_now = spec_o && rel_i && !abort_now;
  assign enter      = !spec_o && acq_i;
  assign rec_en_o   = spec_o && acc_valid_i;
  assign clr_o      = abort_now || commit_now;
  assign new_wr     = (acc_valid_i && acc_wr_i) ?
                      (NUM_LINES'(1) << acc_line_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      save_o     <= 1'b0;
      commit_o   <= 1'b0;
      abort_o    <= 1'b0;
      restore_o  <= 1'b0;
      fallback_o <= 1'b0;
      mask_o     <= '0;
    end else begin
      save_o     <= enter;
      commit_o   <= commit_now;
      abort_o    <= abort_now;
      restore_o  <= abort_now;
      fallback_o <= abort_now && (ovf_i || nest);
      mask_o     <= abort_now ? (wr_bits_i | new_wr) : '0;
      if (clr_o)      st_q <= ST_IDLE;
      else if (enter) st_q <= ST_SPEC;
    end
  end

  // R3
  commit_abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(commit_o && abort_o));

  // R2
  save_then_spec_chk: assert property (@(posedge clk) disable iff (rst)
    save_o |-> spec_o);

  // R7
  mask_only_on_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !abort_o |-> (mask_o == '0));

  // R11
  end_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_o || abort_o) |-> !spec_o);

  // R12
  end_needs_spec_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_o || abort_o) |-> $past(spec_o));

  // R8
  fallback_with_abort_chk: assert property (@(posedge clk) disable iff (rst)
    fallback_o |-> (abort_o && restore_o));
endmodule

// File: rtl/spec_lock_tracker.sv
module spec_lock_tracker #(
  parameter int LINE_W = 6,
  parameter int CAP    = 8,
  localparam int NUM_LINES = 1 << LINE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acq_hint_i,
  input  logic                 rel_hint_i,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic [LINE_W-1:0]    acc_line_i,
  input  logic                 snp_valid_i,
  input  logic [1:0]           snp_kind_i,
  input  logic [LINE_W-1:0]    snp_line_i,
  output logic                 spec_active_o,
  output logic                 ckpt_save_o,
  output logic                 ckpt_restore_o,
  output logic                 commit_o,
  output logic                 abort_o,
  output logic                 fallback_o,
  output logic [NUM_LINES-1:0] inval_mask_o
);
  logic                 rec_en, clr, rd_hit, wr_hit, ovf, conflict;
  logic [NUM_LINES-1:0] wr_bits;

  slt_footprint #(.LINE_W(LINE_W), .CAP(CAP)) fp_i (
    .clk(clk), .rst(rst), .clr_i(clr),
    .rec_en_i(rec_en), .rec_wr_i(acc_write_i), .rec_line_i(acc_line_i),
    .look_line_i(snp_line_i), .look_rd_o(rd_hit), .look_wr_o(wr_hit),
    .ovf_o(ovf), .wr_bits_o(wr_bits)
  );

  slt_snoop_chk snp_i (
    .spec_i(spec_active_o), .snp_valid_i(snp_valid_i), .kind_i(snp_kind_i),
    .rd_hit_i(rd_hit), .wr_hit_i(wr_hit), .conflict_o(conflict)
  );

  slt_ctrl #(.LINE_W(LINE_W)) ctl_i (
    .clk(clk), .rst(rst), .acq_i(acq_hint_i), .rel_i(rel_hint_i),
    .acc_valid_i(acc_valid_i), .acc_wr_i(acc_write_i), .acc_line_i(acc_line_i),
    .conflict_i(conflict), .ovf_i(ovf), .wr_bits_i(wr_bits),
    .spec_o(spec_active_o), .rec_en_o(rec_en), .clr_o(clr),
    .save_o(ckpt_save_o), .commit_o(commit_o), .abort_o(abort_o),
    .restore_o(ckpt_restore_o), .fallback_o(fallback_o), .mask_o(inval_mask_o)
  );

  // R6
  wr_snoop_hit_aborts_chk: assert property (@(posedge clk) disable iff (rst)
    (spec_active_o && snp_valid_i && (snp_kind_i != 2'b00) && (rd_hit || wr_hit))
      |=> abort_o);

  // R4
  rd_rd_no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (spec_active_o && snp_valid_i && (snp_kind_i == 2'b00) && !wr_hit &&
     !acq_hint_i && !ovf && !rel_hint_i) |=> !abort_o && spec_active_o);
endmodule

// File: tb/spec_lock_tracker_tb_top.sv
module spec_lock_tracker_tb_top;
  localparam int LW  = 6;
  localparam int NL  = 1 << LW;
  localparam int CAP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acq, rel, av, aw, sv;
  logic [LW-1:0] al, sl;
  logic [1:0]    sk;
  logic          spec_o, save_o, rest_o, com_o, ab_o, fb_o;
  logic [NL-1:0] mask_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state
  bit [NL-1:0] m_rd, m_wr;
  bit          m_spec;
  int          m_cnt;
  // expected outputs
  bit          e_spec, e_save, e_com, e_ab, e_rest, e_fb;
  bit [NL-1:0] e_mask;

  always #4 clk = ~clk;

  spec_lock_tracker #(.LINE_W(LW), .CAP(CAP)) dut_i (
    .clk(clk), .rst(rst), .acq_hint_i(acq), .rel_hint_i(rel),
    .acc_valid_i(av), .acc_write_i(aw), .acc_line_i(al),
    .snp_valid_i(sv), .snp_kind_i(sk), .snp_line_i(sl),
    .spec_active_o(spec_o), .ckpt_save_o(save_o), .ckpt_restore_o(rest_o),
    .commit_o(com_o), .abort_o(ab_o), .fallback_o(fb_o), .inval_mask_o(mask_o)
  );

  task automatic chk(input logic [NL-1:0] act, input logic [NL-1:0] exp_v,
                     input string req, input string what);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
    end
  endtask

  function automatic void model_step();
    bit hitr, hitw, conf, fresh, ovf, nest, ab, cm, en;
    hitr  = m_rd[sl];
    hitw  = m_wr[sl];
    conf  = m_spec && sv && ((sk == 2'b00) ? hitw : (hitr || hitw));
    fresh = !(m_rd[al] || m_wr[al]);
    ovf   = m_spec && av && fresh && (m_cnt == CAP);
    nest  = m_spec && acq;
    ab    = m_spec && (conf || ovf || nest);
    cm    = m_spec && rel && !ab;
    en    = !m_spec && acq;
    e_save = en;
    e_com  = cm;
    e_ab   = ab;
    e_rest = ab;
    e_fb   = ab && (ovf || nest);
    e_mask = ab ? (m_wr | ((av && aw) ? (NL'(1) << al) : '0)) : '0;
    if (ab || cm) begin
      m_spec = 0; m_rd = '0; m_wr = '0; m_cnt = 0;
    end else if (en) begin
      m_spec = 1;
    end else if (m_spec && av) begin
      if (fresh) m_cnt++;
      if (aw) m_wr[al] = 1'b1;
      else    m_rd[al] = 1'b1;
    end
    e_spec = m_spec;
  endfunction

  // called at a falling edge; applies inputs and compares one cycle later
  task automatic step(input bit a_acq, input bit a_rel, input bit a_av,
                      input bit a_aw, input int a_al, input bit a_sv,
                      input int a_sk, input int a_sl, input string tag);
    acq = a_acq; rel = a_rel; av = a_av; aw = a_aw; al = LW'(a_al);
    sv = a_sv; sk = 2'(a_sk); sl = LW'(a_sl);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(NL'(spec_o), NL'(e_spec), "R2", {tag, " spec_active"});
    chk(NL'(save_o), NL'(e_save), "R2", {tag, " ckpt_save"});
    chk(NL'(com_o),  NL'(e_com),  "R3", {tag, " commit"});
    chk(NL'(ab_o),   NL'(e_ab),   "R5", {tag, " abort"});
    chk(NL'(rest_o), NL'(e_rest), "R7", {tag, " restore"});
    chk(NL'(fb_o),   NL'(e_fb),   "R8", {tag, " fallback"});
    chk(mask_o,      e_mask,      "R7", {tag, " inval_mask"});
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    int seed;
    acq = 0; rel = 0; av = 0; aw = 0; al = '0; sv = 0; sk = '0; sl = '0;
    m_rd = '0; m_wr = '0; m_spec = 0; m_cnt = 0;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    chk({spec_o, save_o, rest_o, com_o, ab_o, fb_o}, '0, "R1", "in reset");
    chk(mask_o, '0, "R1", "mask in reset");
    rst = 1'b0;
    @(negedge clk);
    chk({spec_o, save_o, rest_o, com_o, ab_o, fb_o}, '0, "R1", "after reset");

    // R2 R3: enter, read, write, release
    step(1, 0, 0, 0, 0, 0, 0, 0, "R2 enter");
    step(0, 0, 1, 0, 3, 0, 0, 0, "R3 read");
    step(0, 0, 1, 1, 5, 0, 0, 0, "R3 write");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R3 release");
    // R12: idle traffic ignored
    step(0, 1, 1, 1, 5, 1, 1, 5, "R12 idle traffic");
    step(0, 0, 0, 0, 0, 1, 2, 3, "R12 idle snoop");
    // R4: read-read sharing
    step(1, 0, 0, 0, 0, 0, 0, 0, "R4 enter");
    step(0, 0, 1, 0, 2, 0, 0, 0, "R4 read");
    step(0, 0, 0, 0, 0, 1, 0, 2, "R4 remote read");
    step(0, 1, 0, 0, 0, 0, 0, 0, "R4 release");
    // R5: remote read of written line
    step(1, 0, 0, 0, 0, 0, 0, 0, "R5 enter");
    step(0, 0, 1, 1, 7, 0, 0, 0, "R5 write");
    step(0, 0, 1, 0, 9, 0, 0, 0, "R5 read other");
    step(0, 0, 0, 0, 0, 1, 0, 7, "R5 conflict");
    // R11: fresh region does not see line 7
    step(1, 0, 0, 0, 0, 0, 0, 0, "R11 enter");
    step(0, 0, 0, 0, 0, 1, 1, 7, "R11 stale line");
    // R6: write-class on untouched then touched
    step(0, 0, 1, 0, 4, 0, 0, 0, "R6 read");
    step(0, 0, 0, 0, 0, 1, 1, 12, "R6 untouched");
    step(0, 0, 1, 1, 6, 1, 2, 4, "R6 invalidate + same-cycle store");
    // R8: capacity overflow
    step(1, 0, 0, 0, 0, 0, 0, 0, "R8 enter");
    for (int i = 0; i < CAP + 1; i++)
      step(0, 0, 1, i[0], 20 + i, 0, 0, 0, "R8 fill");
    // R9: nested acquire
    step(1, 0, 0, 0, 0, 0, 0, 0, "R9 enter");
    step(0, 0, 1, 1, 1, 0, 0, 0, "R9 write");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R9 nested");
    // R10: conflict with release
    step(1, 0, 0, 0, 0, 0, 0, 0, "R10 enter");
    step(0, 0, 1, 1, 1, 0, 0, 0, "R10 write");
    step(0, 1, 0, 0, 0, 1, 3, 1, "R10 release+conflict");
    idle("R10 after");

    // random traffic on a narrow band of lines
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 10) == 0, ($urandom % 12) == 0,
           ($urandom % 2) == 0, ($urandom % 2) == 0, int'($urandom % 16),
           ($urandom % 3) == 0, int'($urandom % 4), int'($urandom % 16),
           "R6 R10 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule